// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours, day of month, day of week, month and a two-digit year covering 2000 to 2099, together with a century bit. A base-rate enable strobe feeds an internal prescaler. Every `PRESCALE_DIV` strobes the prescaler produces one one-second advance, and that advance ripples through the whole BCD carry chain in a single clock edge. Month lengths follow the calendar. February has 29 days in every year whose two-digit value is divisible by 4.

Software reaches the block through a byte-wide register port that is written synchronously and read combinationally. To set the clock, software first sets the stop bit. That freezes every counter and clears the prescaler. Software then writes the seven time bytes and clears the stop bit, and the first advance follows one full second after the release. A sticky voltage-low flag in the seconds register marks the contents as untrustworthy. A brown-out input sets the flag, and only a write to the seconds register clears it.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, the registers read ctrl 0x00, seconds 0x80 (voltage-low flag set, seconds 00), minutes 0x00, hours 0x00, day 0x01, weekday 0x06, month 0x01 and year 0x00.
- R2: The address map is ctrl 0x0, seconds 0x2, minutes 0x3, hours 0x4, day 0x5, weekday 0x6, month 0x7 and year 0x8. Address 0x1 and addresses 0x9 to 0xF read 0x00, and writes to them have no effect. In the ctrl register only bit 5 (stop) is stored; the other bits read 0.
- R3: Written values are truncated to the field width: 7 bits for seconds and minutes, 6 bits for hours and day, 3 bits for weekday, 5 bits for month in bits 4:0, and 8 bits for the year. Month bits 6:5 read 0.
- R4: While running, seconds advance by one in BCD once every `PRESCALE_DIV` base strobes. 59 wraps to 00 and carries into minutes in the same edge.
- R5: Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into both the day and the weekday. Weekday counts 0 to 6, with 0 meaning Sunday, and wraps from 6 to 0.
- R6: The day wraps to 01 after the last day of the month: 30 for April, June, September and November, 31 for the other long months, and for February 29 when the BCD year value is divisible by 4 and 28 otherwise.
- R7: Month wraps from 12 to 01 and increments the year. Year wraps from 99 to 00 and toggles the century bit, which is bit 7 of the month register and is also writable there.
- R8: While stop (ctrl bit 5) is set, no field changes except through writes, and the prescaler is held at zero. After stop clears, the first advance happens on exactly the `PRESCALE_DIV`-th base strobe.
- R9: The voltage-low flag (seconds bit 7) is set by the brown-out input and stays set until the seconds register is written. When a brown-out and a seconds write land in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_stb | input | 1 | Base-rate enable strobe, counted by the prescaler |
| brownout | input | 1 | Supply-low indication; sets the voltage-low flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
Some behaviour is checked by the assertions on every cycle. While stop is set, the calendar stays stable unless a write occurs, and a second can never be produced while stop is set. Each non-wrapping second step is exactly +1. Seconds 59 wrap to 00, and a full day rollover brings the hours to 00. The flag properties check that the flag sets on brown-out, is sticky, and is cleared by a seconds write. Other behaviour can only be shown by the bench's scenarios. These include the month-length and leap-year decisions, the year and century wrap, field truncation, the register map, and the exact strobe count to the first advance after a release, which the bench checks with partial prescaler counts.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_SEC  = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_MIN  = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_HOUR = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_DAY  = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_WDAY = 4'h6;
    localparam logic [ADDR_W-1:0] ADR_MON  = 4'h7;
    localparam logic [ADDR_W-1:0] ADR_YEAR = 4'h8;

    localparam int STOP_BIT = 5;
    localparam int VLOW_BIT = 7;
    localparam int CENT_BIT = 7;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] day;
        logic [2:0] wday;
        logic [4:0] mon;
        logic [7:0] year;
        logic       century;
    } cal_t;

    localparam cal_t CAL_RESET = '{
        sec:     7'h00,
        min:     7'h00,
        hour:    6'h00,
        day:     6'h01,
        wday:    3'd6,
        mon:     5'h01,
        year:    8'h00,
        century: 1'b0
    };

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        return (v[3:0] >= 4'h9) ? {v[7:4] + 4'd1, 4'h0} : v + 8'd1;
    endfunction

    function automatic logic [6:0] bcd_inc7(input logic [6:0] v);
        return (v[3:0] >= 4'h9) ? {v[6:4] + 3'd1, 4'h0} : v + 7'd1;
    endfunction

    function automatic logic [5:0] bcd_inc6(input logic [5:0] v);
        return (v[3:0] >= 4'h9) ? {v[5:4] + 2'd1, 4'h0} : v + 6'd1;
    endfunction

    function automatic logic [4:0] bcd_inc5(input logic [4:0] v);
        return (v[3:0] >= 4'h9) ? {v[4] + 1'b1, 4'h0} : v + 5'd1;
    endfunction

    // Year value divisible by four, decided on the binary equivalent of the BCD byte
    function automatic logic leap_year(input logic [7:0] y);
        logic [7:0] bin;
        bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
        return bin[1:0] == 2'b00;
    endfunction

    function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_stb,
    input  logic hold,
    output logic sec_tick
);
    localparam int CW = $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d    = pre_q;
        sec_tick = 1'b0;
        if (hold) begin
            pre_d.cnt = '0;
        end else if (base_stb) begin
            if (pre_q.cnt >= LAST) begin
                pre_d.cnt = '0;
                sec_tick  = 1'b1;
            end else begin
                pre_d.cnt = pre_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic stop_val,
    input  logic wr_sec,
    input  logic brownout,
    output logic stop_o,
    output logic vl_o
);
    typedef struct packed {
        logic stop;
        logic vl;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl)  ctl_d.stop = stop_val;
        if (wr_sec)   ctl_d.vl   = 1'b0;
        if (brownout) ctl_d.vl   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{stop: 1'b0, vl: 1'b1};
        else        ctl_q <= ctl_d;
    end

    assign stop_o = ctl_q.stop;
    assign vl_o   = ctl_q.vl;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wdata,
    output cal_t        cal_o
);
    cal_t cal_d, cal_q;
    logic [5:0] last_day;
    logic c_sec, c_min, c_hour, c_day, c_mon;

    assign last_day = month_last_day(cal_q.mon, cal_q.year);

    always_comb begin
        cal_d  = cal_q;
        c_sec  = adv    && (cal_q.sec  >= 7'h59);
        c_min  = c_sec  && (cal_q.min  >= 7'h59);
        c_hour = c_min  && (cal_q.hour >= 6'h23);
        c_day  = c_hour && (cal_q.day  >= last_day);
        c_mon  = c_day  && (cal_q.mon  >= 5'h12);

        if (adv)    cal_d.sec  = c_sec  ? 7'h00 : bcd_inc7(cal_q.sec);
        if (c_sec)  cal_d.min  = c_min  ? 7'h00 : bcd_inc7(cal_q.min);
        if (c_min)  cal_d.hour = c_hour ? 6'h00 : bcd_inc6(cal_q.hour);
        if (c_hour) begin
            cal_d.day  = c_day ? 6'h01 : bcd_inc6(cal_q.day);
            cal_d.wday = (cal_q.wday >= 3'd6) ? 3'd0 : cal_q.wday + 3'd1;
        end
        if (c_day)  cal_d.mon  = c_mon  ? 5'h01 : bcd_inc5(cal_q.mon);
        if (c_mon) begin
            if (cal_q.year >= 8'h99) begin
                cal_d.year    = 8'h00;
                cal_d.century = ~cal_q.century;
            end else begin
                cal_d.year = bcd_inc8(cal_q.year);
            end
        end

        if (wr_en) begin
            case (wr_addr)
                ADR_SEC:  cal_d.sec  = wdata[6:0];
                ADR_MIN:  cal_d.min  = wdata[6:0];
                ADR_HOUR: cal_d.hour = wdata[5:0];
                ADR_DAY:  cal_d.day  = wdata[5:0];
                ADR_WDAY: cal_d.wday = wdata[2:0];
                ADR_MON: begin
                    cal_d.mon     = wdata[4:0];
                    cal_d.century = wdata[CENT_BIT];
                end
                ADR_YEAR: cal_d.year = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= CAL_RESET;
        else        cal_q <= cal_d;
    end

    assign cal_o = cal_q;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_stb,
    input  logic       brownout,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    cal_t cal_q;
    logic stop_q, vl_q, sec_tick;
    logic wr_ctrl, wr_sec;

    assign wr_ctrl = wr_en && (addr == ADR_CTRL);
    assign wr_sec  = wr_en && (addr == ADR_SEC);

    rtc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_stb (base_stb),
        .hold     (stop_q),
        .sec_tick (sec_tick)
    );

    rtc_ctrl_regs u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .stop_val (wdata[STOP_BIT]),
        .wr_sec   (wr_sec),
        .brownout (brownout),
        .stop_o   (stop_q),
        .vl_o     (vl_q)
    );

    rtc_calendar u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (sec_tick),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wdata   (wdata),
        .cal_o   (cal_q)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: rdata[STOP_BIT] = stop_q;
            ADR_SEC:  rdata = {vl_q, cal_q.sec};
            ADR_MIN:  rdata = {1'b0, cal_q.min};
            ADR_HOUR: rdata = {2'b00, cal_q.hour};
            ADR_DAY:  rdata = {2'b00, cal_q.day};
            ADR_WDAY: rdata = {5'b00000, cal_q.wday};
            ADR_MON:  rdata = {cal_q.century, 2'b00, cal_q.mon};
            ADR_YEAR: rdata = cal_q.year;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] addr,
    input logic       brownout,
    input logic       stop,
    input logic       vl,
    input logic       sec_tick,
    input cal_t       cal
);
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !wr_en |=> $stable(cal)); // R8

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> !stop); // R8

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && !wr_en && cal.sec[3:0] < 4'h9 |=> cal.sec == $past(cal.sec) + 7'd1); // R4

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && !wr_en && cal.sec == 7'h59 |=> cal.sec == 7'h00); // R4

    AST_DAY_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && !wr_en && cal.sec == 7'h59 && cal.min == 7'h59 && cal.hour == 6'h23
        |=> cal.hour == 6'h00 && cal.min == 7'h00); // R5

    AST_VL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        brownout |=> vl); // R9

    AST_VL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        vl && !(wr_en && addr == ADR_SEC) |=> vl); // R9

    AST_VL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == ADR_SEC && !brownout |=> !vl); // R9
endmodule

bind bcd_rtc_core rtc_core_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .brownout (brownout),
    .stop     (stop_q),
    .vl       (vl_q),
    .sec_tick (sec_tick),
    .cal      (cal_q)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam int NVEC = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_stb = 1'b0;
    logic       brownout = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rtc_core #(.PRESCALE_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_stb(base_stb), .brownout(brownout),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // {req, start sec,min,hour,day,wday,mon,year, expected same order}
    localparam logic [119:0] VECS [NVEC] = '{
        {8'd4, 56'h00_00_00_10_03_05_23, 56'h01_00_00_10_03_05_23}, // R4
        {8'd4, 56'h59_34_12_10_03_05_23, 56'h00_35_12_10_03_05_23}, // R4
        {8'd4, 56'h29_59_12_10_03_05_23, 56'h30_59_12_10_03_05_23}, // R4
        {8'd5, 56'h59_59_09_10_03_05_23, 56'h00_00_10_10_03_05_23}, // R5
        {8'd5, 56'h59_59_23_15_06_03_24, 56'h00_00_00_16_00_03_24}, // R5
        {8'd6, 56'h59_59_23_30_02_04_24, 56'h00_00_00_01_03_05_24}, // R6
        {8'd6, 56'h59_59_23_30_02_03_24, 56'h00_00_00_31_03_03_24}, // R6
        {8'd6, 56'h59_59_23_28_01_02_23, 56'h00_00_00_01_02_03_23}, // R6
        {8'd6, 56'h59_59_23_28_01_02_24, 56'h00_00_00_29_02_02_24}, // R6
        {8'd6, 56'h59_59_23_29_04_02_24, 56'h00_00_00_01_05_03_24}, // R6
        {8'd6, 56'h59_59_23_28_01_02_00, 56'h00_00_00_29_02_02_00}, // R6
        {8'd6, 56'h59_59_23_28_01_02_96, 56'h00_00_00_29_02_02_96}, // R6
        {8'd6, 56'h59_59_23_28_01_02_98, 56'h00_00_00_01_02_03_98}, // R6
        {8'd6, 56'h59_59_23_30_05_11_50, 56'h00_00_00_01_06_12_50}, // R6
        {8'd7, 56'h59_59_23_31_05_12_19, 56'h00_00_00_01_06_01_20}, // R7
        {8'd7, 56'h59_59_23_31_05_12_99, 56'h00_00_00_01_06_81_00}, // R7
        {8'd7, 56'h59_59_23_31_05_92_99, 56'h00_00_00_01_06_01_00}  // R7
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); base_stb = 1'b1;
            @(negedge clk); base_stb = 1'b0;
        end
    endtask

    task automatic pulse_bo();
        @(negedge clk); brownout = 1'b1;
        @(negedge clk); brownout = 1'b0;
    endtask

    task automatic read_time(output logic [55:0] t);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            rd(4'(2 + i), b);
            t[55 - 8*i -: 8] = b;
        end
    endtask

    task automatic load_time(input logic [55:0] t);
        wr(4'h0, 8'h20);
        for (int i = 0; i < 7; i++) wr(4'(2 + i), t[55 - 8*i -: 8]);
        wr(4'h0, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [55:0] t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, b); check("R1 ctrl", 64'(b), 64'h00);
        read_time(t); check("R1 time", 64'(t), 64'h80_00_00_01_06_01_00);

        // R2 map holes
        rd(4'h1, b); check("R2 addr1", 64'(b), 64'h00);
        rd(4'hC, b); check("R2 addrC", 64'(b), 64'h00);

        // Vector table: load, release, one second of strobes, read back
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            load_time(VECS[v][111:56]);
            strobe(DIV);
            read_time(t);
            tag = $sformatf("R%0d vec%0d", VECS[v][119:112], v);
            check(tag, 64'(t), 64'(VECS[v][55:0]));
        end

        // R2 writes to reserved addresses and unused ctrl bits
        wr(4'h1, 8'hFF); rd(4'h1, b); check("R2 addr1 write ignored", 64'(b), 64'h00);
        wr(4'h9, 8'hFF); rd(4'h9, b); check("R2 addr9 write ignored", 64'(b), 64'h00);
        wr(4'h0, 8'hFF); rd(4'h0, b); check("R2 ctrl only stop", 64'(b), 64'h20);

        // R3 truncation (stop is set)
        wr(4'h2, 8'hFF); rd(4'h2, b); check("R3 sec", 64'(b), 64'h7F);
        wr(4'h3, 8'hFF); rd(4'h3, b); check("R3 min", 64'(b), 64'h7F);
        wr(4'h4, 8'hFF); rd(4'h4, b); check("R3 hour", 64'(b), 64'h3F);
        wr(4'h5, 8'hFF); rd(4'h5, b); check("R3 day", 64'(b), 64'h3F);
        wr(4'h6, 8'hFF); rd(4'h6, b); check("R3 wday", 64'(b), 64'h07);
        wr(4'h7, 8'h7F); rd(4'h7, b); check("R3 month", 64'(b), 64'h1F);
        wr(4'h8, 8'hA5); rd(4'h8, b); check("R3 year", 64'(b), 64'hA5);

        // R9 voltage-low flag (still stopped)
        wr(4'h2, 8'h05); rd(4'h2, b); check("R9 cleared by sec write", 64'(b), 64'h05);
        pulse_bo();      rd(4'h2, b); check("R9 set by brownout", 64'(b), 64'h85);
        wr(4'h3, 8'h10); rd(4'h2, b); check("R9 sticky on other write", 64'(b), 64'h85);
        @(negedge clk); wr_en = 1'b1; addr = 4'h2; wdata = 8'h07; brownout = 1'b1;
        @(negedge clk); wr_en = 1'b0; brownout = 1'b0;
        rd(4'h2, b); check("R9 brownout wins", 64'(b), 64'h87);
        wr(4'h2, 8'h07); rd(4'h2, b); check("R9 cleared again", 64'(b), 64'h07);

        // R8 stop freezes counting, prescaler restarts on release
        wr(4'h2, 8'h10);
        strobe(3 * DIV);
        rd(4'h2, b); check("R8 frozen sec", 64'(b), 64'h10);
        rd(4'h3, b); check("R8 frozen min", 64'(b), 64'h10);
        wr(4'h0, 8'h00);
        strobe(DIV - 1); rd(4'h2, b); check("R8 no tick before full second", 64'(b), 64'h10);
        strobe(1);       rd(4'h2, b); check("R8 tick at full second", 64'(b), 64'h11);
        strobe(2);
        wr(4'h0, 8'h20);
        wr(4'h0, 8'h00);
        strobe(DIV - 1); rd(4'h2, b); check("R8 prescaler cleared by stop", 64'(b), 64'h11);
        strobe(1);       rd(4'h2, b); check("R8 tick after restart", 64'(b), 64'h12);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule